// File: doc/BRIEF.md
# Two-Wire Bus Condition Detector

This block is the input stage of a slave on a two-wire serial bus. It takes the raw clock and data lines, brings them into the system clock domain and passes each through a spike filter. A filtered line changes only after its input has held the new value for a set number of system clocks. From the two clean lines it produces one-cycle pulses for clock rising edges, clock falling edges, START conditions and STOP conditions, plus a level flag that is high while the bus is free.

A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. A data change while the clock is low is a normal bit change and raises neither pulse. A condition is only accepted if the clock was already high in the previous filtered sample. So a clock edge and a data edge that land in the same sample never form a condition.

The block also paces the slave's own transmitter. Each filtered clock fall starts a hold timer. When the timer expires, a one-cycle `drive_ok` strobe tells the transmitter that it may now change its data output. This keeps that change well clear of the clock edge, so the slave never creates a false START or STOP. The byte-level decoder is outside this block; it takes the pulses and the filtered levels.

Three small state machines do the work:
- **Line filter** (one per line):
  - `FLT_STABLE`: holds the output. It goes to `FLT_QUALIFY` when the synchronized input differs from the output.
  - `FLT_QUALIFY`: counts matching samples. It goes back to `FLT_STABLE` on a mismatch, which rejects the spike, or when the count completes, which flips the output.
- **Bus tracker**:
  - `BUS_FREE`: goes to `BUS_BUSY` on a START.
  - `BUS_BUSY`: goes back to `BUS_FREE` on a STOP.
- **Hold timer**:
  - `TMR_IDLE`: goes to `TMR_COUNT` on a clock fall.
  - `TMR_COUNT`: restarts on another fall. It goes back to `TMR_IDLE` when it expires, and `drive_ok` is high in that cycle.

Top module: `twb_cond_detect`

## Requirements
- R1: While `rst_n` is low and right after it is released, every pulse output is low, `scl_lvl`, `sda_lvl` and `bus_idle` are high, and `drive_ok` is low.
- R2: The change of a raw line that is then held steady shows up as the matching pulse exactly FILT_LEN+2 clock cycles after the first clock edge that samples it. That is 2 synchronizer stages plus FILT_LEN qualifying samples, with the pulse visible in the cycle that follows.
- R3: A raw-line excursion that lasts fewer than FILT_LEN clock samples produces no edge pulse, no condition and no level change. An excursion of FILT_LEN samples or more produces exactly one pulse for each direction.
- R4: `scl_rise` and `scl_fall` are each one cycle wide, one per filtered transition, and never high together.
- R5: `start_det` pulses when filtered SDA falls while filtered SCL is high in both the current and the previous sample.
- R6: `stop_det` pulses when filtered SDA rises while filtered SCL is high in both the current and the previous sample.
- R7: SDA changes while SCL is low, including all data bits of a transfer, raise neither `start_det` nor `stop_det`.
- R8: An SCL rise that lands in the same filtered sample as an SDA fall raises no `start_det`.
- R9: `bus_idle` is high from reset, drops in the cycle after a START pulse, rises in the cycle after a STOP pulse, and otherwise does not change.
- R10: `drive_ok` is a one-cycle pulse exactly HOLD_CYC cycles after an `scl_fall` pulse. A new `scl_fall` before expiry restarts the count, and only the later fall is answered.
- R11: `start_det` and `stop_det` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| scl_lvl | output | 1 | Filtered clock level |
| sda_lvl | output | 1 | Filtered data level |
| scl_rise | output | 1 | One-cycle pulse on a filtered clock rising edge |
| scl_fall | output | 1 | One-cycle pulse on a filtered clock falling edge |
| start_det | output | 1 | One-cycle pulse on a START condition |
| stop_det | output | 1 | One-cycle pulse on a STOP condition |
| bus_idle | output | 1 | High between a STOP (or reset) and the next START |
| drive_ok | output | 1 | One-cycle strobe: transmitter may change its data output |

## Verification
Every edge and condition pulse is due exactly FILT_LEN+2 cycles after the first edge that samples the raw change. `bus_idle` follows one cycle after a START or STOP pulse, and `drive_ok` follows HOLD_CYC cycles after the `scl_fall` pulse. The bench keeps a cycle counter and a monitor that samples on the falling clock edge. The monitor stamps the cycle of every pulse, so the checks compare stamps against the drive cycle plus the computed latency rather than waiting a loose margin. Spike widths from 1 up to past the filter length are swept on both lines, and the expected pulse counts are derived from whether each width reaches FILT_LEN.

// File: rtl/twb_pkg.sv
package twb_pkg;

    typedef enum logic {
        FLT_STABLE  = 1'b0,
        FLT_QUALIFY = 1'b1
    } flt_state_t;

    typedef enum logic {
        BUS_FREE = 1'b0,
        BUS_BUSY = 1'b1
    } bus_state_t;

    typedef enum logic {
        TMR_IDLE  = 1'b0,
        TMR_COUNT = 1'b1
    } tmr_state_t;

    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;
    localparam int NUM_LINES = 2;

endpackage

// File: rtl/twb_line_filter.sv
module twb_line_filter
    import twb_pkg::*;
#(
    parameter int FILT_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          sync1_q, sync2_q;
    flt_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          level_q, level_d;

    // two-stage synchronizer, idles high like the bus
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= raw_i;
            sync2_q <= sync1_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STABLE;
            cnt_q   <= '0;
            level_q <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            level_q <= level_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        level_d = level_q;
        unique case (state_q)
            FLT_STABLE: begin
                if (sync2_q != level_q) begin
                    if (FILT_LEN == 1) begin
                        level_d = sync2_q;
                    end else begin
                        state_d = FLT_QUALIFY;
                        cnt_d   = CW'(1);
                    end
                end
            end
            FLT_QUALIFY: begin
                if (sync2_q == level_q) begin
                    state_d = FLT_STABLE;
                    cnt_d   = '0;
                end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                    state_d = FLT_STABLE;
                    cnt_d   = '0;
                    level_d = sync2_q;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                state_d = FLT_STABLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign level_o = level_q;

endmodule

// File: rtl/twb_cond_fsm.sv
module twb_cond_fsm
    import twb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic bus_idle
);
    logic       scl_p, sda_p;
    bus_state_t state_q, state_d;

    // previous filtered sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_FREE;
        else        state_q <= state_d;
    end

    // outputs: conditions need SCL high in both samples
    always_comb begin
        scl_rise  = scl_f & ~scl_p;
        scl_fall  = ~scl_f & scl_p;
        start_det = scl_f & scl_p & sda_p & ~sda_f;
        stop_det  = scl_f & scl_p & ~sda_p & sda_f;
        bus_idle  = (state_q == BUS_FREE);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_FREE: if (start_det) state_d = BUS_BUSY;
            BUS_BUSY: if (stop_det)  state_d = BUS_FREE;
            default:                 state_d = BUS_FREE;
        endcase
    end

endmodule

// File: rtl/twb_drive_timer.sv
module twb_drive_timer
    import twb_pkg::*;
#(
    parameter int HOLD_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    output logic drive_ok
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    tmr_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output
    always_comb begin
        drive_ok = (state_q == TMR_COUNT) && (cnt_q == CW'(HOLD_CYC));
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (fall_i) begin
            state_d = TMR_COUNT;
            cnt_d   = CW'(1);
        end else begin
            unique case (state_q)
                TMR_IDLE: cnt_d = '0;
                TMR_COUNT: begin
                    if (cnt_q == CW'(HOLD_CYC)) begin
                        state_d = TMR_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                default: begin
                    state_d = TMR_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/twb_cond_detect.sv
module twb_cond_detect
    import twb_pkg::*;
#(
    parameter int FILT_LEN = 6,
    parameter int HOLD_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic bus_idle,
    output logic drive_ok
);
    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] flt_lines;

    assign raw_lines[LINE_SCL] = scl_i;
    assign raw_lines[LINE_SDA] = sda_i;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        twb_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .level_o(flt_lines[g])
        );
    end

    assign scl_lvl = flt_lines[LINE_SCL];
    assign sda_lvl = flt_lines[LINE_SDA];

    twb_cond_fsm u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (flt_lines[LINE_SCL]),
        .sda_f    (flt_lines[LINE_SDA]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .bus_idle (bus_idle)
    );

    twb_drive_timer #(.HOLD_CYC(HOLD_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (scl_fall),
        .drive_ok(drive_ok)
    );

endmodule

// File: rtl/twb_cond_detect_chk.sv
module twb_cond_detect_chk #(
    parameter int HOLD_CYC = 32
) (
    input logic clk,
    input logic rst_n,
    input logic scl_rise,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det,
    input logic bus_idle,
    input logic drive_ok
);
    localparam int SW = $clog2(HOLD_CYC + 2);

    // cycles since last scl_fall pulse; 0 = none yet, saturates
    logic [SW-1:0] since_fall;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               since_fall <= '0;
        else if (scl_fall)                        since_fall <= SW'(1);
        else if (since_fall != '0 &&
                 since_fall != SW'(HOLD_CYC + 1)) since_fall <= since_fall + SW'(1);
    end

    // R11
    cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));

    // R4
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall}));

    // R4
    fall_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |=> !scl_fall);

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !bus_idle);

    // R9
    stop_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> bus_idle);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_det && !stop_det) |=> $stable(bus_idle));

    // R10
    drive_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_ok |-> (since_fall == SW'(HOLD_CYC)));

endmodule

bind twb_cond_detect twb_cond_detect_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .bus_idle (bus_idle),
    .drive_ok (drive_ok)
);

// File: tb/twb_cond_detect_test.sv
module twb_cond_detect_test;
    localparam int CLK_PERIOD = 10;
    localparam int FILT = 3;
    localparam int HOLD = 8;
    localparam int LAT  = FILT + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_i = 1'b1, sda_i = 1'b1;
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det, bus_idle, drive_ok;

    int tests = 0, fails = 0;
    int cyc = 0, drv_cyc = 0;
    int n_rise = 0, n_fall = 0, n_start = 0, n_stop = 0, n_drv = 0;
    int last_rise = -1, last_fall = -1, last_start = -1, last_stop = -1;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    twb_cond_detect #(.FILT_LEN(FILT), .HOLD_CYC(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .bus_idle(bus_idle), .drive_ok(drive_ok)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: stamps pulses and checks timing and exclusivity
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_rise)  begin n_rise++;  last_rise  = cyc; end
            if (scl_fall)  begin n_fall++;  last_fall  = cyc; end
            if (start_det) begin n_start++; last_start = cyc; end
            if (stop_det)  begin n_stop++;  last_stop  = cyc; end
            if (start_det && stop_det) check(0, "R11 start+stop", 1, 0);
            if (scl_rise && scl_fall)  check(0, "R4 rise+fall", 1, 0);
            if (drive_ok) begin
                n_drv++;
                check(cyc - last_fall == HOLD, "R10 drive_ok latency", cyc - last_fall, HOLD);
            end
        end
    end

    task automatic drive(input logic s, input logic d);
        @(negedge clk);
        scl_i = s;
        sda_i = d;
        drv_cyc = cyc;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic hold(input int n);
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        int r0, f0, s0, p0, d0, k;
        logic [8:0] bits;
        // R1 reset state
        repeat (4) @(negedge clk);
        check({scl_rise, scl_fall, start_det, stop_det, drive_ok} == 5'b0, "R1 pulses in reset",
              {scl_rise, scl_fall, start_det, stop_det, drive_ok}, 0);
        rst_n = 1'b1;
        wait_cyc(1);
        check(bus_idle && scl_lvl && sda_lvl, "R1 levels after reset",
              {bus_idle, scl_lvl, sda_lvl}, 7);

        // R2 latency of a held change
        drive(0, 1); k = drv_cyc;
        wait_cyc(12);
        check(last_fall == k + LAT, "R2 fall latency", last_fall, k + LAT);
        check(!scl_lvl, "R2 scl level low", scl_lvl, 0);
        drive(1, 1); k = drv_cyc;
        wait_cyc(12);
        check(last_rise == k + LAT, "R2 rise latency", last_rise, k + LAT);

        // R3 spike sweep on SCL (SDA high)
        for (int w = 1; w <= 5; w++) begin
            r0 = n_rise; f0 = n_fall; s0 = n_start; p0 = n_stop;
            drive(0, 1); hold(w); drive(1, 1);
            wait_cyc(HOLD + 12);
            check(n_fall - f0 == ((w >= FILT) ? 1 : 0), "R3 scl spike falls", n_fall - f0, (w >= FILT) ? 1 : 0);
            check(n_rise - r0 == ((w >= FILT) ? 1 : 0), "R3 scl spike rises", n_rise - r0, (w >= FILT) ? 1 : 0);
            check(n_start == s0 && n_stop == p0, "R3 scl spike no cond", n_start - s0, 0);
        end

        // R3 R5 R6 spike sweep on SDA (SCL high)
        for (int w = 1; w <= 5; w++) begin
            s0 = n_start; p0 = n_stop;
            drive(1, 0); k = drv_cyc; hold(w); drive(1, 1);
            wait_cyc(12);
            check(n_start - s0 == ((w >= FILT) ? 1 : 0), "R5 sda spike starts", n_start - s0, (w >= FILT) ? 1 : 0);
            check(n_stop - p0 == ((w >= FILT) ? 1 : 0), "R6 sda spike stops", n_stop - p0, (w >= FILT) ? 1 : 0);
            if (w >= FILT)
                check(last_start == k + LAT, "R5 start latency", last_start, k + LAT);
            check(bus_idle, "R9 idle after spike", bus_idle, 1);
        end

        // R8 SCL rise with simultaneous SDA fall
        s0 = n_start; p0 = n_stop;
        drive(0, 1); wait_cyc(8);
        drive(1, 0); wait_cyc(8);
        drive(0, 0); wait_cyc(8);
        drive(0, 1); wait_cyc(8);   // R7 data change while SCL low
        drive(1, 1); wait_cyc(12);
        check(n_start == s0, "R8 no start on coincident edges", n_start - s0, 0);
        check(n_stop == p0, "R7 no stop on low-phase change", n_stop - p0, 0);
        check(bus_idle, "R9 idle unchanged", bus_idle, 1);

        // byte transfer: START, 9 bits, STOP
        drive(1, 0); k = drv_cyc;
        wait_cyc(10);
        check(last_start == k + LAT, "R5 start latency", last_start, k + LAT);
        check(!bus_idle, "R9 busy after start", bus_idle, 0);
        r0 = n_rise; f0 = n_fall; s0 = n_start; p0 = n_stop; d0 = n_drv;
        bits = 9'b1_0100_1010;
        for (int b = 8; b >= 0; b--) begin
            drive(0, sda_i); hold(4);
            drive(0, bits[b]); hold(8);
            drive(1, bits[b]); hold(12);
        end
        drive(0, sda_i); hold(4);
        drive(0, 0); hold(8);
        wait_cyc(2);
        check(n_start == s0 && n_stop == p0, "R7 no cond during data", n_start + n_stop - s0 - p0, 0);
        check(n_rise - r0 == 9, "R4 rises per byte", n_rise - r0, 9);
        check(n_fall - f0 == 10, "R4 falls per byte", n_fall - f0, 10);
        check(n_drv - d0 == 10, "R10 drive_ok per fall", n_drv - d0, 10);
        drive(1, 0); wait_cyc(10);
        drive(1, 1); k = drv_cyc;
        wait_cyc(12);
        check(last_stop == k + LAT, "R6 stop latency", last_stop, k + LAT);
        check(n_stop - p0 == 1, "R6 one stop", n_stop - p0, 1);
        check(bus_idle, "R9 idle after stop", bus_idle, 1);

        // R10 restart: second fall before expiry
        d0 = n_drv;
        drive(0, 1); hold(FILT);
        drive(1, 1); hold(FILT);
        drive(0, 1);
        wait_cyc(HOLD + 12);
        drive(1, 1);
        wait_cyc(12);
        check(n_drv - d0 == 1, "R10 restart single strobe", n_drv - d0, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule